// File: doc/BRIEF.md
# Ethernet Command Frame Bus Bridge

This block sits behind a receive front end that has already located the start of a frame and removed the preamble. It watches a two-bit-per-cycle stream, most-significant bit first, whose valid flag is high from the first destination-address bit to the last check-sequence bit. It keeps only frames addressed to this device, or to everyone, that also carry the one configured ethertype. From each such frame it takes a single five-byte command: a one-byte operation flag, a 16-bit address and 16-bit write data.

The command is held back until the frame has ended and a separate frame-check verdict has come in. On a good verdict the block drives a one-cycle request on a simple register bus. A write ends there. A read waits for the bus to return data, then raises a one-cycle transmit start with the 16-bit data. A separate transmitter turns that data into the reply frame. While a reply is still owed, any newly arriving frame is discarded.

Top module: `cmd_frame_bridge`

## Requirements
- R1: After a synchronous active-low reset, bus_req and tx_start are low and tx_data is zero.
- R2: A frame can produce a request only if its first six bytes equal the DEV_MAC parameter or are all 0xFF (broadcast). Any other destination produces no request.
- R3: A frame can produce a request only if bytes 12 and 13, high byte first, equal the ETYPE parameter.
- R4: Byte 14 is the operation flag, where any nonzero value means write and zero means read. Bytes 15-16 are the address and bytes 17-18 the write data, both high byte first. Each byte arrives as four dibits, bits 7:6 first. Bytes after 18 (extra payload, padding, check sequence) have no effect on any output.
- R5: An accepted command raises bus_req for exactly one cycle, in the cycle after fcs_done is seen high with fcs_good high. fcs_done may come in the first cycle with rx_valid low or any later cycle. bus_write, bus_addr and bus_wdata carry the command during that cycle.
- R6: If fcs_done arrives with fcs_good low, the frame produces no request.
- R7: A frame with fewer than 19 bytes produces no request. A 19-byte frame is enough.
- R8: A write produces no transmit start. For a read, the cycle after bus_rvalid is high raises tx_start for one cycle, and tx_data then holds the bus_rdata of that cycle until the next read reply.
- R9: A frame whose first cycle falls while a request, a read reply or a check verdict is still pending produces no request. A pending read reply is still delivered.
- R10: If a new frame starts before the check verdict of an accepted command, that command is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | High for every dibit of a frame |
| rx_dibit | input | 2 | Frame bits, most significant first |
| fcs_done | input | 1 | One-cycle frame-check verdict strobe |
| fcs_good | input | 1 | Verdict: checksum correct, valid with fcs_done |
| bus_req | output | 1 | One-cycle register-bus request |
| bus_write | output | 1 | Request is a write (high) or read (low) |
| bus_addr | output | ADDR_W | Request address |
| bus_wdata | output | DATA_W | Write data |
| bus_rvalid | input | 1 | Read data valid strobe |
| bus_rdata | input | DATA_W | Read data |
| tx_start | output | 1 | One-cycle reply transmit start |
| tx_data | output | DATA_W | Reply data, held until the next reply |

## Verification
The end of a frame and the check verdict can land in the same cycle. The bench provokes this by pulsing fcs_done in the first idle cycle after a read frame, and at other times delays it by several cycles. In both cases the behavioural model expects bus_req exactly one cycle after the verdict. A read reply that is still owed can also overlap with a new frame arriving. The bench holds back bus_rvalid for a long time and sends a complete valid write frame in the meantime. It then judges that the write never reaches the bus and the late read data still reaches tx_data.

// File: rtl/cfb_pkg.sv
// Shared constants and types of the command frame bus bridge.
package cfb_pkg;
    localparam int MAC_BITS  = 48;            // one station address
    localparam int HDR_BITS  = 2 * MAC_BITS;  // destination + source
    localparam int TYPE_BITS = 16;            // ethertype field
    localparam int FLAG_BITS = 8;             // operation flag byte

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_CHECK   = 2'd1,
        SEQ_ISSUE   = 2'd2,
        SEQ_WAIT_RD = 2'd3
    } seq_state_t;
endpackage

// File: rtl/cfb_rx_parser.sv
// Receive parser: walks one frame dibit by dibit, matches destination
// address and ethertype against shifting reference registers, and
// captures the command record that follows the ethertype.
// Assumes rx_valid stays high for the whole frame and drops between
// frames; the stream is most-significant bit first.
module cfb_rx_parser
    import cfb_pkg::*;
#(
    parameter logic [MAC_BITS-1:0]  DEV_MAC   = 48'h02_1A_3C_44_7E_91,
    parameter logic [TYPE_BITS-1:0] ETYPE     = 16'h88B6,
    parameter int                   CMD_BITS  = 40,
    parameter int                   CNT_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic [1:0]          rx_dibit,
    output logic                frame_end,
    output logic                frame_hit,
    output logic [CMD_BITS-1:0] cmd_word
);
    localparam int CMD_LO   = HDR_BITS + TYPE_BITS;
    localparam int CMD_HI   = CMD_LO + CMD_BITS;
    localparam int LAST_POS = CMD_HI - 2;
    localparam int CNT_TOP  = (2 ** CNT_W) - 2;

    logic [CNT_W-1:0]     bit_cnt;
    logic                 valid_q;
    logic                 hit_dev, hit_bc, hit_type, got_cmd;
    logic [MAC_BITS-1:0]  mac_exp;
    logic [TYPE_BITS-1:0] type_exp;
    logic [CMD_BITS-1:0]  cmd_sr;
    logic                 first, in_mac, in_type, in_cmd;

    // Window decode from the bit position of the current dibit.
    always_comb begin
        first   = rx_valid && (bit_cnt == '0);
        in_mac  = bit_cnt < CNT_W'(MAC_BITS);
        in_type = (bit_cnt >= CNT_W'(HDR_BITS)) && (bit_cnt < CNT_W'(CMD_LO));
        in_cmd  = (bit_cnt >= CNT_W'(CMD_LO)) && (bit_cnt < CNT_W'(CMD_HI));
    end

    // Bit position counter: +2 per valid cycle, saturating, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rx_valid;
            if (!rx_valid)
                bit_cnt <= '0;
            else if (bit_cnt != CNT_W'(CNT_TOP))
                bit_cnt <= bit_cnt + CNT_W'(2);
        end
    end

    // Address and ethertype match flags, compared against shifting references.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_dev  <= 1'b0;
            hit_bc   <= 1'b0;
            hit_type <= 1'b0;
            got_cmd  <= 1'b0;
            mac_exp  <= '0;
            type_exp <= '0;
        end else if (first) begin
            hit_dev  <= (rx_dibit == DEV_MAC[MAC_BITS-1 -: 2]);
            hit_bc   <= (rx_dibit == 2'b11);
            hit_type <= 1'b1;
            got_cmd  <= 1'b0;
            mac_exp  <= {DEV_MAC[MAC_BITS-3:0], 2'b00};
            type_exp <= ETYPE;
        end else if (rx_valid) begin
            if (in_mac) begin
                hit_dev <= hit_dev & (rx_dibit == mac_exp[MAC_BITS-1 -: 2]);
                hit_bc  <= hit_bc & (rx_dibit == 2'b11);
                mac_exp <= {mac_exp[MAC_BITS-3:0], 2'b00};
            end
            if (in_type) begin
                hit_type <= hit_type & (rx_dibit == type_exp[TYPE_BITS-1 -: 2]);
                type_exp <= {type_exp[TYPE_BITS-3:0], 2'b00};
            end
            if (bit_cnt == CNT_W'(LAST_POS))
                got_cmd <= 1'b1;
        end
    end

    // Command record shift register, filled only inside the command window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_sr <= '0;
        else if (rx_valid && in_cmd)
            cmd_sr <= {cmd_sr[CMD_BITS-3:0], rx_dibit};
    end

    // Frame-level results toward the sequencer.
    always_comb begin
        frame_end = valid_q && !rx_valid;
        frame_hit = (hit_dev || hit_bc) && hit_type && got_cmd;
        cmd_word  = cmd_sr;
    end
endmodule

// File: rtl/cfb_sequencer.sv
// Command sequencer: latches an accepted command at frame end, waits
// for the frame-check verdict, issues one bus request, and for reads
// forwards the returned data as a transmit start. Frames whose first
// cycle falls outside the idle state are marked and dropped.
module cfb_sequencer
    import cfb_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int CMD_BITS = FLAG_BITS + ADDR_W + DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic                frame_end,
    input  logic                frame_hit,
    input  logic [CMD_BITS-1:0] cmd_word,
    input  logic                fcs_done,
    input  logic                fcs_good,
    input  logic                bus_rvalid,
    input  logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_req,
    output logic                bus_write,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_wdata,
    output logic                tx_start,
    output logic [DATA_W-1:0]   tx_data
);
    seq_state_t          state, state_nxt;
    logic                accept_now;
    logic                skip;
    logic                cmd_wr;
    logic [ADDR_W-1:0]   cmd_addr;
    logic [DATA_W-1:0]   cmd_data;

    // Next-state decision for the command life cycle.
    always_comb begin
        state_nxt  = state;
        accept_now = 1'b0;
        case (state)
            SEQ_IDLE: begin
                if (frame_end && frame_hit && !skip) begin
                    accept_now = 1'b1;
                    if (fcs_done)
                        state_nxt = fcs_good ? SEQ_ISSUE : SEQ_IDLE;
                    else
                        state_nxt = SEQ_CHECK;
                end
            end
            SEQ_CHECK: begin
                if (rx_valid)
                    state_nxt = SEQ_IDLE;
                else if (fcs_done)
                    state_nxt = fcs_good ? SEQ_ISSUE : SEQ_IDLE;
            end
            SEQ_ISSUE:   state_nxt = cmd_wr ? SEQ_IDLE : SEQ_WAIT_RD;
            SEQ_WAIT_RD: if (bus_rvalid) state_nxt = SEQ_IDLE;
            default:     state_nxt = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nxt;
    end

    // Drop marker for frames that begin while the sequencer is busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            skip <= 1'b0;
        else if (frame_end)
            skip <= 1'b0;
        else if (rx_valid && state != SEQ_IDLE)
            skip <= 1'b1;
    end

    // Command holding registers, loaded when a frame is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_wr   <= 1'b0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else if (accept_now) begin
            cmd_wr   <= |cmd_word[CMD_BITS-1 -: FLAG_BITS];
            cmd_addr <= cmd_word[DATA_W +: ADDR_W];
            cmd_data <= cmd_word[DATA_W-1:0];
        end
    end

    // Reply capture and one-cycle transmit start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_start <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_start <= (state == SEQ_WAIT_RD) && bus_rvalid;
            if ((state == SEQ_WAIT_RD) && bus_rvalid)
                tx_data <= bus_rdata;
        end
    end

    // Bus request outputs.
    always_comb begin
        bus_req   = (state == SEQ_ISSUE);
        bus_write = cmd_wr;
        bus_addr  = cmd_addr;
        bus_wdata = cmd_data;
    end
endmodule

// File: rtl/cmd_frame_bridge.sv
// Top of the command frame bus bridge: a receive parser feeding a
// command sequencer. Assumes a de-framed MSB-first dibit stream and
// a separate frame-check verdict strobe at or after frame end.
module cmd_frame_bridge
    import cfb_pkg::*;
#(
    parameter logic [MAC_BITS-1:0]  DEV_MAC = 48'h02_1A_3C_44_7E_91,
    parameter logic [TYPE_BITS-1:0] ETYPE   = 16'h88B6,
    parameter int                   ADDR_W  = 16,
    parameter int                   DATA_W  = 16,
    parameter int                   CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [1:0]        rx_dibit,
    input  logic              fcs_done,
    input  logic              fcs_good,
    output logic              bus_req,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rvalid,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              tx_start,
    output logic [DATA_W-1:0] tx_data
);
    localparam int CMD_BITS = FLAG_BITS + ADDR_W + DATA_W;

    logic                frame_end;
    logic                frame_hit;
    logic [CMD_BITS-1:0] cmd_word;

    cfb_rx_parser #(
        .DEV_MAC  (DEV_MAC),
        .ETYPE    (ETYPE),
        .CMD_BITS (CMD_BITS),
        .CNT_W    (CNT_W)
    ) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_dibit  (rx_dibit),
        .frame_end (frame_end),
        .frame_hit (frame_hit),
        .cmd_word  (cmd_word)
    );

    cfb_sequencer #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CMD_BITS (CMD_BITS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .frame_end  (frame_end),
        .frame_hit  (frame_hit),
        .cmd_word   (cmd_word),
        .fcs_done   (fcs_done),
        .fcs_good   (fcs_good),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .bus_req    (bus_req),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .tx_start   (tx_start),
        .tx_data    (tx_data)
    );
endmodule

// File: rtl/cfb_checker.sv
// Protocol checker for the command frame bus bridge, bound to the top.
// Observes ports only.
module cfb_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fcs_done,
    input logic              fcs_good,
    input logic              bus_req,
    input logic              bus_rvalid,
    input logic              tx_start,
    input logic [DATA_W-1:0] tx_data
);
    // R5
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> !bus_req);

    // R5
    req_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> $past(fcs_done && fcs_good));

    // R8
    tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R8
    tx_after_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(bus_rvalid));

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_data) |-> tx_start);
endmodule

bind cmd_frame_bridge cfb_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fcs_done   (fcs_done),
    .fcs_good   (fcs_good),
    .bus_req    (bus_req),
    .bus_rvalid (bus_rvalid),
    .tx_start   (tx_start),
    .tx_data    (tx_data)
);

// File: tb/cmd_frame_bridge_test.sv
`timescale 1ns/1ps
module cmd_frame_bridge_test;
    localparam logic [47:0] DEV  = 48'h02_1A_3C_44_7E_91;
    localparam logic [47:0] HOST = 48'h00_11_22_33_44_55;
    localparam logic [47:0] BCST = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [15:0] ETY  = 16'h88B6;
    localparam logic [15:0] RMASK = 16'h5A3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [1:0]  rx_dibit = 2'b00;
    logic        fcs_done = 1'b0;
    logic        fcs_good = 1'b0;
    logic        bus_req, bus_write, tx_start;
    logic [15:0] bus_addr, bus_wdata, tx_data;
    logic        bus_rvalid = 1'b0;
    logic [15:0] bus_rdata = 16'h0;

    always #4 clk = ~clk;

    cmd_frame_bridge #(.DEV_MAC(DEV), .ETYPE(ETY)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_dibit(rx_dibit),
        .fcs_done(fcs_done), .fcs_good(fcs_good),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .tx_start(tx_start), .tx_data(tx_data)
    );

    int checks = 0;
    int errors = 0;
    int n_req = 0, n_wr = 0, n_tx = 0;
    int rd_delay = 2;
    logic [15:0] last_addr = 0, last_wdata = 0;
    logic [7:0] fq[$];

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_state = 0;   // 0 idle, 1 awaiting verdict, 2 request, 3 awaiting data
    logic [7:0]  m_q[$];
    logic [7:0]  m_byte = 0;
    int          m_dib = 0;
    bit          m_prev = 0, m_skip = 0, m_wr = 0, m_txs = 0;
    logic [15:0] m_addr = 0, m_wdata = 0, m_txd = 0;

    function automatic bit accept();
        bit dev_ok = 1, bc_ok = 1;
        if (m_q.size() < 19) return 0;
        for (int i = 0; i < 6; i++) begin
            if (m_q[i] != DEV[47-8*i -: 8]) dev_ok = 0;
            if (m_q[i] != 8'hFF) bc_ok = 0;
        end
        return (dev_ok || bc_ok) && (m_q[12] == ETY[15:8]) && (m_q[13] == ETY[7:0]);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_q.delete(); m_dib = 0; m_prev = 0; m_skip = 0;
            m_txs = 0; m_txd = 0;
        end else begin
            bit fe, nx;
            // compare this cycle's outputs (R5 timing, R4 fields, R8 reply)
            check(bus_req === (m_state == 2), "R5", "bus_req", bus_req, m_state == 2);
            if (m_state == 2) begin
                check(bus_write === m_wr, "R4", "bus_write", bus_write, m_wr);
                check(bus_addr === m_addr, "R4", "bus_addr", bus_addr, m_addr);
                if (m_wr) check(bus_wdata === m_wdata, "R4", "bus_wdata", bus_wdata, m_wdata);
            end
            check(tx_start === m_txs, "R8", "tx_start", tx_start, m_txs);
            check(tx_data === m_txd, "R8", "tx_data", tx_data, m_txd);
            if (bus_req) begin
                n_req++; last_addr = bus_addr; last_wdata = bus_wdata;
                if (bus_write) n_wr++;
            end
            if (tx_start) n_tx++;
            // advance model with this cycle's inputs
            fe = m_prev && !rx_valid;
            nx = 0;
            if (rx_valid) begin
                if (m_state != 0) m_skip = 1;
                m_byte = {m_byte[5:0], rx_dibit};
                m_dib++;
                if (m_dib == 4) begin m_q.push_back(m_byte); m_dib = 0; end
            end
            case (m_state)
                0: if (fe && !m_skip && accept()) begin
                       m_wr = (m_q[14] != 0);
                       m_addr = {m_q[15], m_q[16]};
                       m_wdata = {m_q[17], m_q[18]};
                       if (fcs_done) m_state = fcs_good ? 2 : 0;
                       else m_state = 1;
                   end
                1: if (rx_valid) m_state = 0;
                   else if (fcs_done) m_state = fcs_good ? 2 : 0;
                2: m_state = m_wr ? 0 : 3;
                default: if (bus_rvalid) begin m_txd = bus_rdata; nx = 1; m_state = 0; end
            endcase
            if (fe) begin m_skip = 0; m_q.delete(); m_dib = 0; end
            m_txs = nx;
            m_prev = rx_valid;
        end
    end

    // ---------------- bus responder ----------------
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_req && !bus_write) begin
                logic [15:0] a;
                a = bus_addr;
                repeat (rd_delay) @(posedge clk);
                #1 bus_rvalid = 1'b1; bus_rdata = a ^ RMASK;
                @(posedge clk);
                #1 bus_rvalid = 1'b0; bus_rdata = 16'h0;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic build(logic [47:0] dst, logic [15:0] ety, logic [7:0] flag,
                         logic [15:0] addr, logic [15:0] wd, int len);
        logic [7:0] full[$];
        fq.delete();
        for (int i = 0; i < 6; i++) full.push_back(dst[47-8*i -: 8]);
        for (int i = 0; i < 6; i++) full.push_back(HOST[47-8*i -: 8]);
        full.push_back(ety[15:8]); full.push_back(ety[7:0]);
        full.push_back(flag);
        full.push_back(addr[15:8]); full.push_back(addr[7:0]);
        full.push_back(wd[15:8]); full.push_back(wd[7:0]);
        for (int i = 19; i < len; i++) full.push_back(8'(i * 37 + 5));
        for (int i = 0; i < len; i++) fq.push_back(full[i]);
    endtask

    // Drive fq; verdict delay 0 means the first idle cycle, <0 means none.
    task automatic send(int vdelay, bit good);
        foreach (fq[i]) begin
            for (int d = 3; d >= 0; d--) begin
                rx_valid = 1'b1;
                rx_dibit = fq[i][2*d +: 2];
                @(posedge clk); #1;
            end
        end
        rx_valid = 1'b0; rx_dibit = 2'b00;
        if (vdelay >= 0) begin
            repeat (vdelay) begin @(posedge clk); #1; end
            fcs_done = 1'b1; fcs_good = good;
            @(posedge clk); #1;
            fcs_done = 1'b0; fcs_good = 1'b0;
        end
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R5 watchdog: run did not complete, actual 1 expected 0");
        summary();
    end

    initial begin
        int r0, w0, t0;
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        check(bus_req === 1'b0, "R1", "bus_req in reset", bus_req, 0);
        check(tx_start === 1'b0, "R1", "tx_start in reset", tx_start, 0);
        check(tx_data === 16'h0, "R1", "tx_data in reset", tx_data, 0);
        rst_n = 1'b1;
        idle(3);

        // R4/R5: write to own address, verdict two cycles late; no reply (R8)
        r0 = n_req; t0 = n_tx;
        build(DEV, ETY, 8'h01, 16'h1234, 16'hBEEF, 64); send(2, 1); idle(20);
        check(n_req == r0 + 1, "R5", "write request count", n_req - r0, 1);
        check(last_addr == 16'h1234 && last_wdata == 16'hBEEF, "R4", "write fields", {last_addr, last_wdata}, 32'h1234BEEF);
        check(n_tx == t0, "R8", "write gives no reply", n_tx - t0, 0);

        // R8/R5: read with verdict in the first idle cycle
        r0 = n_req; t0 = n_tx;
        build(DEV, ETY, 8'h00, 16'h00A7, 16'h7777, 64); send(0, 1); idle(20);
        check(n_req == r0 + 1, "R5", "read request count", n_req - r0, 1);
        check(n_tx == t0 + 1, "R8", "read reply count", n_tx - t0, 1);
        check(tx_data == (16'h00A7 ^ RMASK), "R8", "reply data", tx_data, 16'h00A7 ^ RMASK);

        // R2: wrong destination
        r0 = n_req;
        build(48'h02_1A_3C_44_7E_90, ETY, 8'h01, 16'h0001, 16'h0002, 64); send(1, 1); idle(20);
        check(n_req == r0, "R2", "foreign destination dropped", n_req - r0, 0);

        // R3: wrong ethertype
        r0 = n_req;
        build(DEV, 16'h88B7, 8'h01, 16'h0003, 16'h0004, 64); send(1, 1); idle(20);
        check(n_req == r0, "R3", "foreign ethertype dropped", n_req - r0, 0);

        // R2/R4: broadcast write with flag 0x80; tx_data must stay (R8)
        r0 = n_req; w0 = n_wr;
        build(BCST, ETY, 8'h80, 16'hC0DE, 16'h5555, 64); send(3, 1); idle(20);
        check(n_req == r0 + 1 && n_wr == w0 + 1, "R2", "broadcast write accepted", n_wr - w0, 1);
        check(last_addr == 16'hC0DE, "R4", "broadcast address", last_addr, 16'hC0DE);
        check(tx_data == (16'h00A7 ^ RMASK), "R8", "reply data held", tx_data, 16'h00A7 ^ RMASK);

        // R7: 18-byte frame dropped, 19-byte frame accepted
        r0 = n_req;
        build(DEV, ETY, 8'h01, 16'h0B0B, 16'h0C0C, 18); send(0, 1); idle(20);
        check(n_req == r0, "R7", "18-byte frame dropped", n_req - r0, 0);
        build(DEV, ETY, 8'h01, 16'h0D0D, 16'h0E0E, 19); send(0, 1); idle(20);
        check(n_req == r0 + 1, "R7", "19-byte frame accepted", n_req - r0, 1);

        // R6: bad checksum
        r0 = n_req;
        build(DEV, ETY, 8'h01, 16'h0F0F, 16'h1111, 64); send(1, 0); idle(20);
        check(n_req == r0, "R6", "bad checksum dropped", n_req - r0, 0);

        // R9: new frame during a pending read reply
        r0 = n_req; t0 = n_tx; rd_delay = 320;
        build(DEV, ETY, 8'h00, 16'h2222, 16'h0000, 64); send(1, 1); idle(4);
        build(DEV, ETY, 8'h01, 16'h3333, 16'h4444, 64); send(1, 1); idle(120);
        check(n_req == r0 + 1, "R9", "frame during pending reply dropped", n_req - r0, 1);
        check(n_tx == t0 + 1, "R9", "pending reply delivered", n_tx - t0, 1);
        check(tx_data == (16'h2222 ^ RMASK), "R9", "pending reply data", tx_data, 16'h2222 ^ RMASK);
        rd_delay = 2;

        // R10: new frame before verdict discards the waiting command
        r0 = n_req;
        build(DEV, ETY, 8'h01, 16'h5151, 16'h6161, 64); send(-1, 1); idle(3);
        build(DEV, ETY, 8'h01, 16'h7171, 16'h8181, 64); send(1, 1); idle(20);
        check(n_req == r0, "R10", "command without verdict discarded", n_req - r0, 0);
        build(DEV, ETY, 8'h01, 16'h9191, 16'hA1A1, 64); send(1, 1); idle(20);
        check(n_req == r0 + 1 && last_addr == 16'h9191, "R10", "recovery after discard", last_addr, 16'h9191);

        summary();
    end
endmodule